// File: doc/BRIEF.md
# Light-Load Diode-Emulation Mode Sequencer

This block chooses, once per clock, whether a multiphase buck regulator runs in forced continuous conduction or in diode emulation with discontinuous conduction. Diode emulation is granted only after the inductor current has crossed zero on a fixed run of back-to-back switching cycles. A switching-cycle strobe and a zero-crossing flag come from the analog front end. The output voltage code comes from the converter.

Once diode emulation is active, the block treats the two directions of a VID change differently. A rise in the target drops diode emulation and requests active drive until the output reaches the new target. The block then returns to continuous mode, and diode emulation must be earned again with a fresh zero-crossing run. A fall in the target keeps diode emulation, so the load discharges the output. Meanwhile the block tells the protection logic to ignore overvoltage until the output is inside a fixed window above the new target.

All voltages are unsigned millivolt codes of one width. `vid_prev` is the target that was in force before the latest change, and `vid_now` is the target now requested.

Top module: `lldem_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `de_en`, `drive_up` and `ov_blank` are all 0 and the zero-crossing run count is empty.
- R2: In continuous mode, `de_en` rises on the clock edge that samples the ZC_RUN-th consecutive strobed cycle with `zc_flag`=1. The default ZC_RUN is 4.
- R3: In continuous mode, a strobed cycle with `zc_flag`=0 empties the run count. Clock cycles with `cyc_stb`=0 leave the count unchanged, whatever `zc_flag` is.
- R4: While `de_en`=1, if `vid_now` > `vid_prev` and `vout_code` < `vid_now`, the next edge sets `de_en`=0 and `drive_up`=1.
- R5: `drive_up` stays 1 until an edge samples `vout_code` >= `vid_now`. That edge clears both `drive_up` and `de_en`, leaving an empty run count, so a full new run is needed before `de_en` rises again.
- R6: While `de_en`=1 with no upward request, if `vid_now` < `vid_prev` and `vout_code` >= `vid_now` + WIN_MV, the next edge sets `ov_blank`=1 and `de_en` stays 1. The default WIN_MV is 60.
- R7: While `ov_blank`=1 with no upward request, the edge that samples `vout_code` < `vid_now` + WIN_MV clears `ov_blank`, and `de_en` stays 1.
- R8: In continuous mode, differences between `vid_now` and `vid_prev` are ignored: `drive_up` and `ov_blank` stay 0.
- R9: An upward request while `ov_blank`=1 clears `ov_blank` and sets `drive_up` on the next edge. At every cycle, `drive_up` and `ov_blank` are never both 1, `drive_up`=1 implies `de_en`=0, and `ov_blank`=1 implies `de_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_stb | input | 1 | One-cycle strobe per switching cycle |
| zc_flag | input | 1 | Inductor current crossed zero in this switching cycle |
| vid_now | input | VW | Requested target, mV |
| vid_prev | input | VW | Target before the latest change, mV |
| vout_code | input | VW | Sampled output voltage, mV |
| de_en | output | 1 | Diode emulation enabled |
| drive_up | output | 1 | Active drive toward a higher target requested |
| ov_blank | output | 1 | Overvoltage detection to be ignored |

## Verification
Every output is decoded from one registered mode. Each result is therefore due on the first rising edge that samples the inputs that cause it. The exception is the R2 entry, which is due on the edge of the last strobe in the run. The bench drives inputs on the falling edge and reads outputs one time unit after the next rising edge. There it compares them with a reference model stepped once per edge. A directed section places runs, gaps, window boundaries (target + 59 against target + 60) and direction reversals at known edges. A seeded random section follows.

// File: rtl/lldem_pkg.sv
package lldem_pkg;
  typedef enum logic [1:0] {
    MODE_CCM   = 2'd0,
    MODE_DE    = 2'd1,
    MODE_RAMP  = 2'd2,
    MODE_BLANK = 2'd3
  } lldem_mode_e;
endpackage

// File: rtl/lldem_zc_counter.sv
module lldem_zc_counter #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clr,
  input  logic stb,
  input  logic zc,
  output logic run_done
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign run_done = stb && zc && (cnt_q == LAST) && !hold_clr;
  assign cnt_en   = hold_clr || stb;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_clr)      cnt_d = '0;
    else if (!zc)      cnt_d = '0;
    else if (run_done) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lldem_vid_cmp.sv
module lldem_vid_cmp #(
  parameter int VW     = 12,
  parameter int WIN_MV = 60
) (
  input  logic [VW-1:0] vid_now,
  input  logic [VW-1:0] vid_prev,
  input  logic [VW-1:0] vout_code,
  output logic          up_req,
  output logic          dn_far,
  output logic          in_window,
  output logic          reached
);
  localparam logic [VW:0] WIN_C = (VW+1)'(WIN_MV);

  logic [VW:0] win_top;
  logic [VW:0] vout_x;

  assign win_top   = {1'b0, vid_now} + WIN_C;
  assign vout_x    = {1'b0, vout_code};
  assign reached   = vout_code >= vid_now;
  assign up_req    = (vid_now > vid_prev) && !reached;
  assign in_window = vout_x < win_top;
  assign dn_far    = (vid_now < vid_prev) && !in_window;
endmodule

// File: rtl/lldem_mode_fsm.sv
module lldem_mode_fsm
  import lldem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_done,
  input  logic up_req,
  input  logic dn_far,
  input  logic in_window,
  input  logic reached,
  output logic in_ccm,
  output logic de_en,
  output logic drive_up,
  output logic ov_blank
);
  lldem_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_CCM: begin
        if (run_done) mode_d = MODE_DE;
      end
      MODE_DE: begin
        if (up_req)      mode_d = MODE_RAMP;
        else if (dn_far) mode_d = MODE_BLANK;
      end
      MODE_RAMP: begin
        if (reached) mode_d = MODE_CCM;
      end
      MODE_BLANK: begin
        if (up_req)         mode_d = MODE_RAMP;
        else if (in_window) mode_d = MODE_DE;
      end
      default: mode_d = MODE_CCM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_CCM;
    else        mode_q <= mode_d;
  end

  assign in_ccm   = (mode_q == MODE_CCM);
  assign de_en    = (mode_q == MODE_DE) || (mode_q == MODE_BLANK);
  assign drive_up = (mode_q == MODE_RAMP);
  assign ov_blank = (mode_q == MODE_BLANK);
endmodule

// File: rtl/lldem_seq.sv
module lldem_seq #(
  parameter int VW     = 12,
  parameter int ZC_RUN = 4,
  parameter int WIN_MV = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_stb,
  input  logic          zc_flag,
  input  logic [VW-1:0] vid_now,
  input  logic [VW-1:0] vid_prev,
  input  logic [VW-1:0] vout_code,
  output logic          de_en,
  output logic          drive_up,
  output logic          ov_blank
);
  logic run_done, in_ccm;
  logic up_req, dn_far, in_window, reached;

  lldem_zc_counter #(.RUN(ZC_RUN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_clr (!in_ccm),
    .stb      (cyc_stb),
    .zc       (zc_flag),
    .run_done (run_done)
  );

  lldem_vid_cmp #(.VW(VW), .WIN_MV(WIN_MV)) u_cmp (
    .vid_now   (vid_now),
    .vid_prev  (vid_prev),
    .vout_code (vout_code),
    .up_req    (up_req),
    .dn_far    (dn_far),
    .in_window (in_window),
    .reached   (reached)
  );

  lldem_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_done  (run_done),
    .up_req    (up_req),
    .dn_far    (dn_far),
    .in_window (in_window),
    .reached   (reached),
    .in_ccm    (in_ccm),
    .de_en     (de_en),
    .drive_up  (drive_up),
    .ov_blank  (ov_blank)
  );
endmodule

// File: rtl/lldem_seq_chk.sv
module lldem_seq_chk #(
  parameter int VW     = 12,
  parameter int WIN_MV = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_stb,
  input logic          zc_flag,
  input logic [VW-1:0] vid_now,
  input logic [VW-1:0] vid_prev,
  input logic [VW-1:0] vout_code,
  input logic          de_en,
  input logic          drive_up,
  input logic          ov_blank
);
  logic [VW:0] top_c;
  logic        upc;
  assign top_c = {1'b0, vid_now} + (VW+1)'(WIN_MV);
  assign upc   = (vid_now > vid_prev) && (vout_code < vid_now);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_up && ov_blank) && !(drive_up && de_en) && (!ov_blank || de_en));

  p_entry_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_en && !drive_up && !(cyc_stb && zc_flag)) |=> !de_en);

  p_quiet_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_en && !drive_up && !cyc_stb) |=> !de_en);

  p_up_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (de_en && upc) |=> (drive_up && !de_en));

  p_up_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_up && vout_code >= vid_now) |=> (!drive_up && !de_en));

  p_blank_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_blank && !upc && ({1'b0, vout_code} < top_c)) |=> (!ov_blank && de_en));

  p_ccm_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_en && !drive_up) |=> !ov_blank);
endmodule

bind lldem_seq lldem_seq_chk #(.VW(VW), .WIN_MV(WIN_MV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_stb   (cyc_stb),
  .zc_flag   (zc_flag),
  .vid_now   (vid_now),
  .vid_prev  (vid_prev),
  .vout_code (vout_code),
  .de_en     (de_en),
  .drive_up  (drive_up),
  .ov_blank  (ov_blank)
);

// File: tb/lldem_seq_test.sv
module lldem_seq_test;
  localparam int VW = 12;
  localparam int RUN = 4;
  localparam int WIN = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_stb = 1'b0, zc_flag = 1'b0;
  logic [VW-1:0] vid_now = 12'd900, vid_prev = 12'd900, vout_code = 12'd900;
  logic de_en, drive_up, ov_blank;

  int checks = 0, errors = 0;
  int m_mode = 0;  // 0 continuous, 1 diode emulation, 2 drive up, 3 blanked
  int m_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lldem_seq #(.VW(VW), .ZC_RUN(RUN), .WIN_MV(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .zc_flag(zc_flag),
    .vid_now(vid_now), .vid_prev(vid_prev), .vout_code(vout_code),
    .de_en(de_en), .drive_up(drive_up), .ov_blank(ov_blank));

  function automatic bit f_up(int vn, int vp, int vo);
    return (vn > vp) && (vo < vn);
  endfunction
  function automatic bit f_far(int vn, int vp, int vo);
    return (vn < vp) && (vo >= vn + WIN);
  endfunction

  task automatic model_step();
    int vn = int'(vid_now), vp = int'(vid_prev), vo = int'(vout_code);
    case (m_mode)
      0: if (cyc_stb) begin
           if (!zc_flag) m_cnt = 0;
           else if (m_cnt == RUN - 1) begin m_cnt = 0; m_mode = 1; end
           else m_cnt++;
         end
      1: if (f_up(vn, vp, vo)) m_mode = 2;
         else if (f_far(vn, vp, vo)) m_mode = 3;
      2: if (vo >= vn) m_mode = 0;
      default: if (f_up(vn, vp, vo)) m_mode = 2;
               else if (vo < vn + WIN) m_mode = 1;
    endcase
  endtask

  task automatic compare(string tag);
    bit e_de = (m_mode == 1) || (m_mode == 3);
    bit e_up = (m_mode == 2);
    bit e_bl = (m_mode == 3);
    checks++;
    if ({de_en, drive_up, ov_blank} !== {e_de, e_up, e_bl}) begin
      errors++;
      $display("FAIL %s: de/up/blank actual %b%b%b expected %b%b%b",
               tag, de_en, drive_up, ov_blank, e_de, e_up, e_bl);
    end
  endtask

  task automatic tick(bit s, bit z, int vn, int vp, int vo, string tag);
    @(negedge clk);
    cyc_stb = s; zc_flag = z;
    vid_now = VW'(vn); vid_prev = VW'(vp); vout_code = VW'(vo);
    @(posedge clk);
    #1;
    model_step();
    compare(tag);
  endtask

  task automatic enter_de(string tag);
    for (int i = 0; i < RUN; i++) tick(1, 1, 900, 900, 900, tag);
  endtask

  initial begin
    #1;
    compare("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release");

    // R3: three crossings, a miss, gaps with zc high but no strobe
    for (int i = 0; i < RUN - 1; i++) tick(1, 1, 900, 900, 900, "R3 partial run");
    tick(1, 0, 900, 900, 900, "R3 miss clears run");
    for (int i = 0; i < RUN - 1; i++) tick(1, 1, 900, 900, 900, "R3 rebuild");
    tick(0, 1, 900, 900, 900, "R3 no strobe ignored");
    tick(0, 0, 900, 900, 900, "R3 no strobe holds count");
    // R8: transitions ignored in continuous mode
    tick(0, 0, 1000, 900, 800, "R8 up ignored");
    tick(0, 0, 800, 900, 1000, "R8 down ignored");
    tick(1, 1, 900, 900, 900, "R2 last crossing enters DE");

    // R6 boundary: exactly target + 59 is inside the window, no blanking
    tick(0, 0, 800, 900, 859, "R6 inside window no blank");
    tick(0, 0, 800, 900, 860, "R6 blank at window edge");
    tick(0, 0, 800, 900, 900, "R7 still far keeps blank");
    tick(0, 0, 800, 900, 859, "R7 blank clears in window");
    tick(0, 0, 800, 900, 900, "R6 blank again");
    tick(0, 0, 1000, 800, 900, "R9 up during blank");
    tick(1, 1, 1000, 800, 999, "R5 below target holds drive");
    tick(0, 0, 1000, 800, 1000, "R5 reached returns to continuous");
    tick(1, 1, 1000, 800, 1000, "R5 fresh run needed");
    for (int i = 0; i < RUN - 1; i++) tick(1, 1, 1000, 800, 1000, "R5 rerun");

    enter_de("R2 re-entry");
    tick(0, 0, 1100, 1000, 1050, "R4 up request");
    tick(0, 0, 1100, 1000, 1200, "R5 overshoot ends drive");

    // seeded random section
    begin
      int seed = 13;
      int unused = $urandom(seed);
      for (int i = 0; i < 3000; i++) begin
        int vn = 850 + int'($urandom_range(0, 150));
        int vp = 850 + int'($urandom_range(0, 150));
        int vo = 800 + int'($urandom_range(0, 250));
        bit s  = ($urandom_range(0, 3) != 0);
        bit z  = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 2) == 0) vp = vn;
        tick(s, z, vn, vp, vo, "R9 random");
      end
      if (unused < 0) $display("seed note");
    end

    // reset in the middle of diode emulation
    enter_de("R2 before reset");
    @(negedge clk); rst_n = 1'b0; m_mode = 0; m_cnt = 0;
    #1 compare("R1 reset from DE");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 released again");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule